// File: doc/BRIEF.md
# Low-Power Stop and Wake Controller

This block decides when the processor core may give up its clocks and when it gets them back. Software programs two supervisor-only registers. The wake control register holds a stop-enable bit and a 3-bit wake priority threshold. The mode register selects one of four power modes. Later, the core halts on a STOP instruction and reports this on a status bus. If the selected mode permits it, the controller drops the core clock enable. In the deepest mode it also drops the system clock enable.

While the core sleeps, the controller compares the highest unmasked interrupt level against the programmed threshold. This comparison is combinational, so the wake decision needs no clock from the gated domain. A level strictly above the threshold restores both clock enables. It also raises a one-cycle acknowledge so that the core can resume.

Top module: `lpwr_ctrl`

## Requirements
- R1: After a synchronous reset, both registers read 0x00, `core_clk_en` and `sys_clk_en` are 1, and `wake_ack` is 0.
- R2: Wake control register (`reg_sel`=0) fields: bit 7 is stop-enable and bits 6:4 are the wake threshold. Bits 3:0 read as zero and ignore writes.
- R3: Mode register (`reg_sel`=1) uses bits 1:0 for the mode: 00 run, 01 doze, 10 wait, 11 stop. Bits 7:2 read as zero and ignore writes.
- R4: A supervisor access (`bus_super`=1) pulses `bus_done` in the cycle after the request. A user access (`bus_super`=0) leaves both registers unchanged, returns 0 on `bus_rdata`, and pulses `bus_err` instead.
- R5: In doze or wait mode, `core_status` equal to STOP_CODE (default 4'hE) sampled in run state makes `core_clk_en` fall two clock edges later, while `sys_clk_en` stays 1.
- R6: In stop mode with stop-enable set, the same entry makes both `core_clk_en` and `sys_clk_en` fall two edges later.
- R7: If the mode is run, or the mode is stop with stop-enable clear, a STOP status has no effect and both clock enables stay 1.
- R8: In low power, an `irq_level` strictly greater than the threshold sets both clock enables to 1 at the next edge. `wake_ack` is 1 for exactly that one cycle.
- R9: An `irq_level` less than or equal to the threshold never wakes the core. Level 0 means no request, and a threshold of 7 blocks every wake.
- R10: A STOP status seen outside run state is ignored. Holding it during low power neither changes the clock enables nor delays the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | 0 selects wake control register, 1 selects mode register |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_super | input | 1 | 1 when the access is made in supervisor mode |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_done | output | 1 | Access completed normally (pulse) |
| bus_err | output | 1 | Access refused, transfer error (pulse) |
| core_status | input | STATUS_W | Processor status code from the core |
| irq_level | input | 3 | Highest unmasked pending interrupt level, 0 = none |
| core_clk_en | output | 1 | Enable for the high-speed core clock domain |
| sys_clk_en | output | 1 | Enable for the system clock domain |
| wake_ack | output | 1 | One-cycle pulse telling the core to resume |

## Verification
A state machine stuck outside run would appear at the ports immediately: `core_clk_en` would stay low, or a second STOP would fail to gate it two edges later. A wrong threshold comparison would show in the cycle after the interrupt level is applied, as a clock enable that rises too early or never rises. A register that latches user writes or reserved bits would be exposed on the next supervisor read. A latched mode that was taken wrongly would show as a wrong `sys_clk_en` value two edges after entry.

// File: rtl/lpwr_pkg.sv
package lpwr_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PEND = 2'd1,
    ST_LP   = 2'd2,
    ST_WAKE = 2'd3
  } lp_state_t;

  typedef enum logic [1:0] {
    MD_RUN  = 2'b00,
    MD_DOZE = 2'b01,
    MD_WAIT = 2'b10,
    MD_STOP = 2'b11
  } lp_mode_t;

  localparam int STOPEN_BIT = 7;
  localparam int THR_LSB    = 4;
endpackage

// File: rtl/lpwr_regs.sv
module lpwr_regs
  import lpwr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_super,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_done,
  output logic              bus_err,
  output logic              stop_en,
  output logic [LVL_W-1:0]  thresh,
  output lp_mode_t          mode
);
  localparam int THR_MSB = THR_LSB + LVL_W - 1;

  logic              access;
  logic [DATA_W-1:0] wctl_view;
  logic [DATA_W-1:0] mode_view;
  logic              unused_wbits;

  assign access       = bus_wr | bus_rd;
  assign unused_wbits = ^{bus_wdata[THR_LSB-1:0], bus_wdata[DATA_W-1:2]};

  always_comb begin
    wctl_view                   = '0;
    wctl_view[STOPEN_BIT]       = stop_en;
    wctl_view[THR_MSB:THR_LSB]  = thresh;
    mode_view                   = '0;
    mode_view[1:0]              = mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_en   <= 1'b0;
      thresh    <= '0;
      mode      <= MD_RUN;
      bus_rdata <= '0;
      bus_done  <= 1'b0;
      bus_err   <= 1'b0;
    end else begin
      bus_done  <= access & bus_super;
      bus_err   <= access & ~bus_super;
      bus_rdata <= '0;
      if (access && bus_super) begin
        if (bus_wr) begin
          if (!reg_sel) begin
            stop_en <= bus_wdata[STOPEN_BIT];
            thresh  <= bus_wdata[THR_MSB:THR_LSB];
          end else begin
            mode    <= lp_mode_t'(bus_wdata[1:0]);
          end
        end
        if (bus_rd) bus_rdata <= reg_sel ? mode_view : wctl_view;
      end
    end
  end

  // R4: user accesses leave the registers untouched
  a_r4_user_no_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_super) |=> ($stable(thresh) && $stable(stop_en) && $stable(mode)));
  // R4: a response is either done or error, never both
  a_r4_resp_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(bus_done && bus_err));
  // R4: refused reads return zero
  a_r4_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_rdata == '0));
endmodule

// File: rtl/lpwr_wake.sv
module lpwr_wake #(
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] irq_level,
  input  logic [LVL_W-1:0] thresh,
  output logic             wake_req
);
  // strict compare: a zero level can never exceed any threshold
  assign wake_req = (irq_level > thresh);
endmodule

// File: rtl/lpwr_fsm.sv
module lpwr_fsm
  import lpwr_pkg::*;
#(
  parameter int              STATUS_W  = 4,
  parameter logic [STATUS_W-1:0] STOP_CODE = 4'hE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [STATUS_W-1:0] core_status,
  input  lp_mode_t            mode,
  input  logic                stop_en,
  input  logic                wake_req,
  output logic                core_clk_en,
  output logic                sys_clk_en,
  output logic                wake_ack
);
  lp_state_t state;
  lp_mode_t  lat_mode;
  logic      stop_seen;
  logic      entry_ok;

  assign stop_seen = (core_status == STOP_CODE);
  assign entry_ok  = (mode == MD_DOZE) || (mode == MD_WAIT) ||
                     ((mode == MD_STOP) && stop_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RUN;
      lat_mode    <= MD_RUN;
      core_clk_en <= 1'b1;
      sys_clk_en  <= 1'b1;
      wake_ack    <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          wake_ack <= 1'b0;
          if (stop_seen && entry_ok) begin
            state    <= ST_PEND;
            lat_mode <= mode;
          end
        end
        ST_PEND: begin
          state       <= ST_LP;
          core_clk_en <= 1'b0;
          sys_clk_en  <= (lat_mode != MD_STOP);
        end
        ST_LP: begin
          if (wake_req) begin
            state       <= ST_WAKE;
            core_clk_en <= 1'b1;
            sys_clk_en  <= 1'b1;
            wake_ack    <= 1'b1;
          end
        end
        default: begin
          state    <= ST_RUN;
          wake_ack <= 1'b0;
        end
      endcase
    end
  end

  // R5: the core clock is only gated while sleeping
  a_r5_gate_only_lp: assert property (@(posedge clk) disable iff (rst)
    !core_clk_en |-> (state == ST_LP));
  // R6: the system clock never stops while the core clock runs
  a_r6_sys_under_core: assert property (@(posedge clk) disable iff (rst)
    !sys_clk_en |-> !core_clk_en);
  // R7: stop without its enable bit stays in run
  a_r7_stop_needs_en: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && stop_seen && mode == MD_STOP && !stop_en) |=> (state == ST_RUN));
  // R8: the acknowledge lasts a single cycle
  a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
    wake_ack |=> !wake_ack);
  // R9: no qualifying request keeps the clocks off
  a_r9_hold_asleep: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LP && !wake_req) |=> !core_clk_en);
endmodule

// File: rtl/lpwr_ctrl.sv
module lpwr_ctrl
  import lpwr_pkg::*;
#(
  parameter int                  STATUS_W  = 4,
  parameter logic [STATUS_W-1:0] STOP_CODE = 4'hE,
  parameter int                  LVL_W     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_sel,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic                bus_super,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic                bus_done,
  output logic                bus_err,
  input  logic [STATUS_W-1:0] core_status,
  input  logic [LVL_W-1:0]    irq_level,
  output logic                core_clk_en,
  output logic                sys_clk_en,
  output logic                wake_ack
);
  localparam int DATA_W = 8;

  logic             stop_en;
  logic [LVL_W-1:0] thresh;
  lp_mode_t         mode;
  logic             wake_req;

  lpwr_regs #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_super(bus_super), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_done(bus_done), .bus_err(bus_err), .stop_en(stop_en),
    .thresh(thresh), .mode(mode)
  );

  lpwr_wake #(.LVL_W(LVL_W)) u_wake (
    .irq_level(irq_level), .thresh(thresh), .wake_req(wake_req)
  );

  lpwr_fsm #(.STATUS_W(STATUS_W), .STOP_CODE(STOP_CODE)) u_fsm (
    .clk(clk), .rst(rst), .core_status(core_status), .mode(mode),
    .stop_en(stop_en), .wake_req(wake_req), .core_clk_en(core_clk_en),
    .sys_clk_en(sys_clk_en), .wake_ack(wake_ack)
  );
endmodule

// File: tb/tb_lpwr_ctrl.sv
module tb_lpwr_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       reg_sel, bus_wr, bus_rd, bus_super;
  logic [7:0] bus_wdata, bus_rdata;
  logic       bus_done, bus_err;
  logic [3:0] core_status;
  logic [2:0] irq_level;
  logic       core_clk_en, sys_clk_en, wake_ack;

  int n_checks = 0;
  int n_fail   = 0;
  localparam logic [3:0] STOPC = 4'hE;

  always #2 clk = ~clk;

  lpwr_ctrl dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_super(bus_super), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_done(bus_done), .bus_err(bus_err), .core_status(core_status),
    .irq_level(irq_level), .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en),
    .wake_ack(wake_ack)
  );

  function automatic bit exp_enter(logic [1:0] md, logic en);
    return (md == 2'b01) || (md == 2'b10) || (md == 2'b11 && en);
  endfunction

  function automatic bit exp_wake(logic [2:0] lvl, logic [2:0] thr);
    return lvl > thr;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(logic sel, logic wr, logic [7:0] d, logic sup, output logic [7:0] rd);
    reg_sel = sel; bus_wr = wr; bus_rd = ~wr; bus_wdata = d; bus_super = sup;
    tick();
    bus_wr = 0; bus_rd = 0; bus_super = 0;
    chk("R4 done", {7'd0, bus_done}, {7'd0, sup});
    chk("R4 err", {7'd0, bus_err}, {7'd0, ~sup});
    rd = bus_rdata;
  endtask

  task automatic wreg(logic sel, logic [7:0] d);
    logic [7:0] x;
    access(sel, 1'b1, d, 1'b1, x);
  endtask

  task automatic rreg(logic sel, output logic [7:0] v);
    access(sel, 1'b0, 8'h00, 1'b1, v);
  endtask

  task automatic do_reset();
    rst = 1; tick(2); rst = 0; tick();
  endtask

  // issue STOP for one cycle and return after the gate edge
  task automatic enter(logic [1:0] md, logic en, string req);
    bit e = exp_enter(md, en);
    core_status = STOPC; tick();
    core_status = 4'h0;
    chk({req, " clk on after 1 edge"}, {7'd0, core_clk_en}, 8'd1);
    tick();
    chk({req, " core gate"}, {7'd0, core_clk_en}, {7'd0, ~e});
    chk({req, " sys gate"}, {7'd0, sys_clk_en}, {7'd0, ~(e && md == 2'b11)});
  endtask

  task automatic try_wake(logic [2:0] lvl, logic [2:0] thr, string req);
    bit w = exp_wake(lvl, thr);
    irq_level = lvl; tick();
    irq_level = 0;
    chk({req, " core en"}, {7'd0, core_clk_en}, {7'd0, w});
    chk({req, " ack"}, {7'd0, wake_ack}, {7'd0, w});
    if (w) begin
      tick();
      chk({req, " ack drop"}, {7'd0, wake_ack}, 8'd0);
    end
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    rst = 1; reg_sel = 0; bus_wr = 0; bus_rd = 0; bus_super = 0; bus_wdata = 0;
    core_status = 0; irq_level = 0;
    tick(3); rst = 0; tick();

    // R1 reset state
    chk("R1 core_clk_en", {7'd0, core_clk_en}, 8'd1);
    chk("R1 sys_clk_en", {7'd0, sys_clk_en}, 8'd1);
    chk("R1 wake_ack", {7'd0, wake_ack}, 8'd0);
    rreg(0, v); chk("R1 wake reg", v, 8'h00);
    rreg(1, v); chk("R1 mode reg", v, 8'h00);

    // R2 / R3 field layout and reserved bits
    wreg(0, 8'hFF); rreg(0, v); chk("R2 reserved low bits", v, 8'hF0);
    wreg(0, 8'h5A); rreg(0, v); chk("R2 threshold field", v, 8'h50);
    wreg(1, 8'hFE); rreg(1, v); chk("R3 mode bits", v, 8'h02);

    // R4 user accesses
    access(0, 1'b1, 8'hA0, 1'b0, v);
    access(1, 1'b1, 8'h03, 1'b0, v);
    access(0, 1'b0, 8'h00, 1'b0, v); chk("R4 user read zero", v, 8'h00);
    rreg(0, v); chk("R4 wake reg kept", v, 8'h50);
    rreg(1, v); chk("R4 mode reg kept", v, 8'h02);

    // R7 run mode and stop without enable
    wreg(0, 8'h00); wreg(1, 8'h00); enter(2'b00, 1'b0, "R7 run mode");
    wreg(1, 8'h03); enter(2'b11, 1'b0, "R7 stop no enable");

    // R5 doze, R10 held STOP, R9 level 0
    wreg(0, 8'h30); wreg(1, 8'h01); enter(2'b01, 1'b0, "R5 doze");
    core_status = STOPC;
    try_wake(3'd0, 3'd3, "R9 level zero");
    try_wake(3'd3, 3'd3, "R9 equal level");
    tick(2);
    chk("R10 held stop", {7'd0, core_clk_en}, 8'd0);
    try_wake(3'd4, 3'd3, "R10 wake with stop held");
    core_status = 0; tick();

    // R6 stop with enable
    wreg(0, 8'h90); wreg(1, 8'h03); enter(2'b11, 1'b1, "R6 stop");
    try_wake(3'd2, 3'd1, "R8 stop wake");
    chk("R8 sys back", {7'd0, sys_clk_en}, 8'd1);

    // random mix (thresholds 0..6)
    for (int i = 0; i < 40; i++) begin
      logic [2:0] thr = 3'($urandom_range(0, 6));
      logic [1:0] md  = 2'($urandom_range(1, 3));
      logic [2:0] lvl = 3'($urandom_range(0, 7));
      wreg(0, {1'b1, thr, 4'h0}); wreg(1, {6'd0, md});
      enter(md, 1'b1, "R5 random entry");
      try_wake(lvl, thr, "R9 random level");
      if (!exp_wake(lvl, thr)) try_wake(3'd7, thr, "R8 random wake");
      tick();
    end

    // R9 threshold 7 blocks every level
    wreg(0, 8'hF0); wreg(1, 8'h02); enter(2'b10, 1'b0, "R5 wait");
    for (int l = 0; l < 8; l++) try_wake(3'(l), 3'd7, "R9 threshold seven");
    do_reset();
    chk("R1 after reset", {7'd0, core_clk_en}, 8'd1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule